// File: doc/BRIEF.md
# DMA Channel Mode and Address Sequencer

This block holds the 8-bit control register of one DMA channel and advances the channel's 24-bit memory address after every completed transfer. The control register selects the transfer width (byte or 16-bit word) and the address direction (up or down). A repeat bit in the control register combines with an interrupt-enable input from a separate register to choose one of three modes: sequential, repeat or idle. A 16-bit transfer counter counts the completed transfers. When it runs out, the channel either stops and may raise a one-cycle end interrupt, or it reloads and keeps going.

Software reaches three registers through one write/read port with a 2-bit select field: the control register, the address and the count. Writing the address or the count also loads a shadow copy of that value, and repeat mode reloads from these copies. A write of a non-zero count arms the channel. The data-moving engine reports each finished transfer with a single-cycle strobe.

Top module: `dma_chan_seq`

## Requirements
- R1: After the active-low asynchronous reset, the control register, address and count are zero, the channel is inactive and irq_o is low.
- R2: standby_i high at a clock edge clears the control register to 0x00, even when a control write arrives in the same cycle. Address, count and channel state are not changed.
- R3: reg_rdata_o is combinational from reg_sel_i. Select 0 returns the control register in bits 7:0, select 1 returns the address, select 2 returns the count in bits 15:0, and select 3 returns zero. Unused upper bits read zero. All 8 control bits read back as written. Writes use the same selects.
- R4: Control bit 7 sets the step (0 gives 1, 1 gives 2). Control bit 6 sets the direction (0 adds the step, 1 subtracts it). The address wraps modulo 2^24.
- R5: Control bit 5 and ie_i select the mode. Bit5=0 gives sequential mode. Bit5=1 with ie_i=0 gives repeat mode. Bit5=1 with ie_i=1 gives idle mode. In idle mode the address does not change on a transfer.
- R6: A count write loads the count and its shadow copy, and the channel becomes active exactly when the written value is non-zero. Each xfer_done_i strobe while the channel is active decrements the count. Strobes while inactive change nothing.
- R7: In sequential or idle mode, the strobe that takes the count from 1 to 0 makes the channel inactive. If ie_i is high, irq_o is high for exactly the next cycle, the same cycle in which the count reads zero.
- R8: In repeat mode, the strobe that takes the count from 1 reloads the address and the count from their shadow copies. The channel stays active and irq_o stays low.
- R9: An address write in the same cycle as a strobe sets the address to the written value. The strobe still decrements the count.
- R10: A count write in the same cycle as a strobe loads the written count. That strobe causes no decrement, no terminal event and no address step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Clears the control register |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 control, 1 address, 2 count |
| reg_wdata_i | input | 24 | Write data |
| reg_rdata_o | output | 24 | Read data for the selected register |
| ie_i | input | 1 | Interrupt enable from a separate register |
| xfer_done_i | input | 1 | One-cycle strobe per completed transfer |
| addr_o | output | 24 | Current memory address |
| count_o | output | 16 | Remaining transfer count |
| active_o | output | 1 | Channel armed and counting |
| irq_o | output | 1 | One-cycle transfer-end interrupt |

## Verification
A register write and a transfer strobe can fall in the same cycle. The bench provokes this twice: once with an address write against a mid-block strobe, and once with a count write against the strobe that would otherwise be terminal. A behavioural model compares every cycle. For the address write, the written address must win while the count still drops by one. For the count write, the written count must appear with no step, no stop and no interrupt.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned BIT_WORD = 7;
  localparam int unsigned BIT_DEC  = 6;
  localparam int unsigned BIT_RPT  = 5;

  typedef enum logic [1:0] {
    MODE_SEQ    = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_IDLE   = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } sel_e;
endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import dma_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              ie_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              word_o,
  output logic              dec_o,
  output mode_e             mode_o
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (standby_i) ctrl_q <= '0;
    else if (we_i)      ctrl_q <= wdata_i;
  end

  always_comb begin
    unique case ({ctrl_q[BIT_RPT], ie_i})
      2'b10:   mode_o = MODE_REPEAT;
      2'b11:   mode_o = MODE_IDLE;
      default: mode_o = MODE_SEQ;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign word_o = ctrl_q[BIT_WORD];
  assign dec_o  = ctrl_q[BIT_DEC];

  assert_standby_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (ctrl_q == '0));
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          done_i,
  input  logic          last_i,
  input  mode_e         mode_i,
  input  logic          word_i,
  input  logic          dec_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, shadow_q, step;

  assign step = word_i ? AW'(2) : AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      shadow_q <= '0;
    end else if (we_i) begin
      addr_q   <= wdata_i;
      shadow_q <= wdata_i;
    end else if (done_i) begin
      if (mode_i == MODE_REPEAT && last_i) addr_q <= shadow_q;
      else if (mode_i != MODE_IDLE)        addr_q <= dec_i ? addr_q - step : addr_q + step;
    end
  end

  assign addr_o = addr_q;

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !we_i && mode_i == MODE_IDLE) |=> $stable(addr_q));
  assert_addr_write_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (addr_q == $past(wdata_i)));
  assert_repeat_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && last_i && !we_i && mode_i == MODE_REPEAT) |=> (addr_q == $past(shadow_q)));
endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt
  import dma_seq_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          strobe_i,
  input  mode_e         mode_i,
  input  logic          ie_i,
  output logic          done_o,
  output logic          last_o,
  output logic [CW-1:0] cnt_o,
  output logic          active_o,
  output logic          irq_o
);
  logic [CW-1:0] cnt_q, shadow_q;
  logic          active_q, irq_q;

  // a count write masks the strobe of the same cycle
  assign done_o = strobe_i && active_q && !we_i;
  assign last_o = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      active_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= done_o && last_o && (mode_i != MODE_REPEAT) && ie_i;
      if (we_i) begin
        cnt_q    <= wdata_i;
        shadow_q <= wdata_i;
        active_q <= (wdata_i != '0);
      end else if (done_o) begin
        if (!last_o)                    cnt_q <= cnt_q - CW'(1);
        else if (mode_i == MODE_REPEAT) cnt_q <= shadow_q;
        else begin
          cnt_q    <= '0;
          active_q <= 1'b0;
        end
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign active_o = active_q;
  assign irq_o    = irq_q;

  assert_active_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q != '0));
  assert_irq_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  assert_irq_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (!active_q || $past(we_i)));
  assert_repeat_no_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> ($past(mode_i) != MODE_REPEAT));
  assert_count_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cnt_q == $past(wdata_i) && !irq_q));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          standby_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  input  logic          ie_i,
  input  logic          xfer_done_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] count_o,
  output logic          active_o,
  output logic          irq_o
);
  logic [CTRL_W-1:0] ctrl;
  logic              word, dec, done, last;
  logic              we_ctrl, we_addr, we_cnt;
  mode_e             mode;

  assign we_ctrl = reg_we_i && (reg_sel_i == SEL_CTRL);
  assign we_addr = reg_we_i && (reg_sel_i == SEL_ADDR);
  assign we_cnt  = reg_we_i && (reg_sel_i == SEL_COUNT);

  dma_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .standby_i (standby_i),
    .we_i      (we_ctrl),
    .wdata_i   (reg_wdata_i[CTRL_W-1:0]),
    .ie_i      (ie_i),
    .ctrl_o    (ctrl),
    .word_o    (word),
    .dec_o     (dec),
    .mode_o    (mode)
  );

  dma_xfer_cnt #(.CW(CW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_cnt),
    .wdata_i  (reg_wdata_i[CW-1:0]),
    .strobe_i (xfer_done_i),
    .mode_i   (mode),
    .ie_i     (ie_i),
    .done_o   (done),
    .last_o   (last),
    .cnt_o    (count_o),
    .active_o (active_o),
    .irq_o    (irq_o)
  );

  dma_addr_seq #(.AW(AW)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_addr),
    .wdata_i (reg_wdata_i),
    .done_i  (done),
    .last_i  (last),
    .mode_i  (mode),
    .word_i  (word),
    .dec_i   (dec),
    .addr_o  (addr_o)
  );

  always_comb begin
    unique case (reg_sel_i)
      SEL_CTRL:  reg_rdata_o = AW'(ctrl);
      SEL_ADDR:  reg_rdata_o = addr_o;
      SEL_COUNT: reg_rdata_o = AW'(count_o);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        standby = 1'b0, we = 1'b0, ie = 1'b0, xd = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [23:0] wd = '0, rdata, addr;
  logic [15:0] cnt;
  logic        act, irq;

  int checks = 0, failures = 0;
  bit done_flag = 0;
  string tag = "R1";

  // reference model state
  logic [7:0]  m_ctrl;
  logic [23:0] m_addr, m_ash;
  logic [15:0] m_cnt, m_csh;
  logic        m_act, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_seq u_dma_chan_seq (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .reg_we_i(we),
    .reg_sel_i(sel), .reg_wdata_i(wd), .reg_rdata_o(rdata), .ie_i(ie),
    .xfer_done_i(xd), .addr_o(addr), .count_o(cnt), .active_o(act), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_addr = 0; m_ash = 0; m_cnt = 0; m_csh = 0; m_act = 0; m_irq = 0;
    end else begin
      bit rpt, idle, eff, term;
      logic [7:0] n_ctrl; logic [23:0] n_addr, n_ash, stepv;
      logic [15:0] n_cnt, n_csh; logic n_act, n_irq;
      rpt  = m_ctrl[5] && !ie;
      idle = m_ctrl[5] && ie;
      eff  = xd && m_act && !(we && sel == 2);
      term = eff && (m_cnt == 1);
      stepv = m_ctrl[7] ? 24'd2 : 24'd1;
      n_ctrl = m_ctrl; n_addr = m_addr; n_ash = m_ash;
      n_cnt = m_cnt; n_csh = m_csh; n_act = m_act;
      n_irq = term && !rpt && ie;
      if (standby) n_ctrl = 0;
      else if (we && sel == 0) n_ctrl = wd[7:0];
      if (we && sel == 1) begin n_addr = wd; n_ash = wd; end
      else if (eff) begin
        if (term && rpt) n_addr = m_ash;
        else if (!idle) n_addr = m_ctrl[6] ? m_addr - stepv : m_addr + stepv;
      end
      if (we && sel == 2) begin n_cnt = wd[15:0]; n_csh = wd[15:0]; n_act = (wd[15:0] != 0); end
      else if (eff) begin
        if (!term) n_cnt = m_cnt - 1;
        else if (rpt) n_cnt = m_csh;
        else begin n_cnt = 0; n_act = 0; end
      end
      m_ctrl = n_ctrl; m_addr = n_addr; m_ash = n_ash;
      m_cnt = n_cnt; m_csh = n_csh; m_act = n_act; m_irq = n_irq;
    end
  end

  task automatic chk(string what, logic [23:0] a, logic [23:0] e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, a, e);
    end
  endtask

  task automatic compare();
    logic [23:0] e_rd;
    case (sel)
      2'd0: e_rd = {16'd0, m_ctrl};
      2'd1: e_rd = m_addr;
      2'd2: e_rd = {8'd0, m_cnt};
      default: e_rd = '0;
    endcase
    chk("addr", addr, m_addr);
    chk("count", {8'd0, cnt}, {8'd0, m_cnt});
    chk("active", {23'd0, act}, {23'd0, m_act});
    chk("irq", {23'd0, irq}, {23'd0, m_irq});
    chk("rdata", rdata, e_rd);
  endtask

  // one cycle: inputs set after negedge, outputs checked at following negedge
  task automatic cyc(string t, bit w, logic [1:0] s, logic [23:0] d, bit x, bit sb = 0);
    tag = t; we = w; sel = s; wd = d; xd = x; standby = sb;
    @(negedge clk);
    compare();
  endtask

  task automatic wr(string t, logic [1:0] s, logic [23:0] d);
    cyc(t, 1, s, d, 0);
  endtask

  task automatic run(string t, int n);
    for (int i = 0; i < n; i++) cyc(t, 0, 2'(i % 4), 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    cyc("R1", 0, 0, 0, 0);
    cyc("R3", 0, 3, 0, 0);
    // R3 readback of every control bit
    wr("R3", 0, 24'h00001F); cyc("R3", 0, 0, 0, 0);
    wr("R3", 0, 24'hFFFFE5); cyc("R3", 0, 0, 0, 0);
    // R6 strobes while inactive
    run("R6", 3);
    // R4 byte increment with wrap
    wr("R4", 0, 24'h000000); wr("R4", 1, 24'hFFFFFE); wr("R4", 2, 24'd5);
    run("R4", 6);
    // R4 word increment, byte decrement wrap, word decrement
    wr("R4", 0, 24'h80); wr("R4", 1, 24'hFFFFFD); wr("R4", 2, 24'd4); run("R4", 5);
    wr("R4", 0, 24'h40); wr("R4", 1, 24'h000001); wr("R4", 2, 24'd4); run("R4", 5);
    wr("R4", 0, 24'hC0); wr("R4", 1, 24'h000002); wr("R4", 2, 24'd3); run("R4", 4);
    // R7 sequential with interrupt
    ie = 1'b1;
    wr("R7", 0, 24'h00); wr("R7", 1, 24'h400); wr("R7", 2, 24'd2); run("R7", 4);
    // R8 repeat mode, word decrement
    ie = 1'b0;
    wr("R8", 0, 24'hE0); wr("R8", 1, 24'h100); wr("R8", 2, 24'd3); run("R8", 8);
    // R5 idle mode holds address, interrupt at end
    ie = 1'b1;
    wr("R5", 0, 24'h20); wr("R5", 1, 24'h200); wr("R5", 2, 24'd3); run("R5", 5);
    // R9 address write against strobe
    ie = 1'b0;
    wr("R9", 0, 24'h80); wr("R9", 1, 24'h300); wr("R9", 2, 24'd4);
    cyc("R9", 0, 1, 0, 1); cyc("R9", 1, 1, 24'h7A7A7A, 1); run("R9", 3);
    // R10 count write against terminal strobe
    ie = 1'b1;
    wr("R10", 0, 24'h00); wr("R10", 2, 24'd1);
    cyc("R10", 1, 2, 24'd2, 1); cyc("R10", 0, 2, 0, 0); run("R10", 3);
    // R6 zero count write stops channel
    wr("R6", 2, 24'd5); run("R6", 1); wr("R6", 2, 24'd0); run("R6", 2);
    // R2 standby wins over control write, leaves address/count
    wr("R2", 0, 24'hA5); wr("R2", 2, 24'd7);
    cyc("R2", 1, 0, 24'h5A, 0, 1); cyc("R2", 0, 0, 0, 0); cyc("R2", 0, 2, 0, 1);
    // mixed traffic under the model
    for (int i = 0; i < 200; i++) begin
      ie = i[5];
      cyc("R6", (i % 13) == 0, 2'(i % 3), 24'(i * 37 + 1), (i % 3) != 0, (i % 57) == 56);
    end
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done_flag) begin
      checks++; failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule